// File: doc/BRIEF.md
# Direct-Mapped Address Translation and Protection Unit

This block turns a 32-bit virtual address into a physical address within the cycle of the request and decides whether the access is allowed. Pages are 8 KB. Two separate direct-mapped tables are kept, one for instruction fetches and one for loads and stores. Each table has 64 slots. A slot holds two words:

- a tag word, carrying the virtual page tag and a valid flag;
- a frame word, carrying the physical frame and the access-permission flags.

Software fills the slots through a single register-write port.

Each request supplies a virtual address, the access kind and the privilege level. The unit returns three things in the same cycle: a result code, the physical address and the rights that were granted.

A miss or a protection fault on a valid request is recorded one cycle later in an exception register:

- the cause code, which tells a fetch miss, a data miss, a fetch fault and a data fault apart;
- the faulting virtual address.

A global enable can switch translation off. The unit then passes every address through unchanged, with full rights.

Top module: `tlb_xlate_unit`

## Requirements
- R1: With `xlate_en` low, every request returns code 0 (hit), `rsp_paddr` equal to `req_vaddr`, rights 3'b111, and never raises an exception.
- R2: The slot is chosen by virtual address bits [18:13]. The result is a miss (code 1) when tag word bits [31:13] differ from virtual address bits [31:13].
- R3: Tag word bit 0 is the valid flag. A slot whose tag matches but whose valid flag is clear gives a miss (code 1), exactly like a tag mismatch.
- R4: `req_kind` with bit 1 set is a fetch, and fetches use the instruction table. The execute right is frame word bit 7 when `priv_sup` is high and bit 6 when it is low. A fetch without execute right gives a fault (code 2).
- R5: `req_kind` 0 is a load and 1 is a store, and both use the data table. In user mode, read comes from frame word bit 6 and write from bit 7. In supervisor mode, read comes from bit 8 and write from bit 9. A load without read right or a store without write right gives a fault (code 2).
- R6: On a translated hit, `rsp_paddr` is frame word bits [31:13] joined to virtual address bits [12:0]. `rsp_rights` is {execute, write, read} for the selected table and mode, and the other bits are 0. On a miss or a fault, `rsp_paddr` and `rsp_rights` are 0.
- R7: One cycle after a valid request that misses or faults, `exc_valid` is high for one cycle and `exc_cause` is set as follows: 1 for a fetch miss, 2 for a data miss, 3 for a fetch fault, 4 for a data fault. The cause is held until the next exception.
- R8: `exc_addr` captures the faulting virtual address in the same cycle that `exc_valid` goes high. Hits, pass-through requests and idle cycles leave it unchanged.
- R9: A write selects the table with `wr_side` (1 = instruction, 0 = data) and the word with `wr_sel` (0 = tag word, 1 = frame word). A write to one table never changes lookups in the other.
- R10: Reset clears every slot and the exception register to zero. A write takes effect for requests from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlate_en | input | 1 | Translation enable; 0 = pass-through |
| priv_sup | input | 1 | 1 = supervisor mode, 0 = user mode |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 load, 1 store, 2 or 3 fetch |
| wr_en | input | 1 | Slot write strobe |
| wr_side | input | 1 | 1 instruction table, 0 data table |
| wr_sel | input | 1 | 0 tag word, 1 frame word |
| wr_idx | input | 6 | Slot number to write |
| wr_data | input | 32 | Word to write |
| rsp_code | output | 2 | 0 hit, 1 miss, 2 fault |
| rsp_paddr | output | 32 | Physical address |
| rsp_rights | output | 3 | Granted rights {execute, write, read} |
| exc_valid | output | 1 | One-cycle exception pulse |
| exc_cause | output | 3 | Last exception cause |
| exc_addr | output | 32 | Last faulting virtual address |

## Verification
The response outputs are combinational. They are valid in the same cycle as the request. The exception pulse, the cause and the captured address appear one clock edge later. A slot write becomes visible only to requests that start after the write edge.

The driver applies each request at the falling edge and queues the expected item. The monitor samples a quarter period after the next rising edge. At that point the request inputs are still held, so the combinational response still belongs to that request, and the exception register has already taken the same request's result. One sample therefore checks both latencies.

Writes are kept a full cycle apart from the requests that depend on them.

// File: rtl/tlb_xlate_pkg.sv
package tlb_xlate_pkg;

  typedef enum logic [1:0] {
    RES_HIT   = 2'd0,
    RES_MISS  = 2'd1,
    RES_FAULT = 2'd2
  } res_e;

  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_IMISS  = 3'd1,
    CAUSE_DMISS  = 3'd2,
    CAUSE_IFAULT = 3'd3,
    CAUSE_DFAULT = 3'd4
  } cause_e;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } rights_t;

  // Low bit of the 4-bit permission field inside the frame word
  localparam int unsigned PERM_LSB = 6;

  // pf[0]..pf[3] are frame word bits 6..9
  function automatic rights_t rights_decode(input logic fetch, input logic sup,
                                            input logic [3:0] pf);
    rights_t g;
    g = '0;
    if (fetch) begin
      g.x = sup ? pf[1] : pf[0];
    end else begin
      g.r = sup ? pf[2] : pf[0];
      g.w = sup ? pf[3] : pf[1];
    end
    return g;
  endfunction

  function automatic logic access_ok(input logic fetch, input logic store,
                                     input rights_t g);
    if (fetch)      return g.x;
    else if (store) return g.w;
    else            return g.r;
  endfunction

  function automatic cause_e cause_of(input logic fetch, input res_e res);
    if (res == RES_MISS)  return fetch ? CAUSE_IMISS : CAUSE_DMISS;
    if (res == RES_FAULT) return fetch ? CAUSE_IFAULT : CAUSE_DFAULT;
    return CAUSE_NONE;
  endfunction

endpackage

// File: rtl/tlb_slot_store.sv
module tlb_slot_store #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_tag_word,
  output logic [WORD_W-1:0] rd_frame_word
);
  localparam int unsigned SLOTS = 1 << IDX_W;

  logic [WORD_W-1:0] tag_q   [SLOTS];
  logic [WORD_W-1:0] frame_q [SLOTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        tag_q[i]   <= '0;
        frame_q[i] <= '0;
      end
    end else if (wr_en) begin
      if (wr_sel) frame_q[wr_idx] <= wr_data;
      else        tag_q[wr_idx]   <= wr_data;
    end
  end

  assign rd_tag_word   = tag_q[rd_idx];
  assign rd_frame_word = frame_q[rd_idx];
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlb_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 13
) (
  input  logic              xlate_en,
  input  logic              fetch,
  input  logic              store,
  input  logic              sup,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [ADDR_W-1:0] tag_word,
  input  logic [ADDR_W-1:0] frame_word,
  output logic [1:0]        code,
  output logic [ADDR_W-1:0] paddr,
  output logic [2:0]        rights,
  output logic              tag_hit,
  output logic              ent_valid
);
  localparam int unsigned VPN_W = ADDR_W - OFS_W;

  rights_t grant;
  res_e    res;

  always_comb begin
    tag_hit   = (tag_word[ADDR_W-1:OFS_W] == vaddr[ADDR_W-1:OFS_W]);
    ent_valid = tag_word[0];
    grant     = rights_decode(fetch, sup, frame_word[PERM_LSB +: 4]);
    if (!xlate_en) begin
      res    = RES_HIT;
      paddr  = vaddr;
      rights = 3'b111;
    end else if (!tag_hit || !ent_valid) begin
      res    = RES_MISS;
      paddr  = '0;
      rights = '0;
    end else if (!access_ok(fetch, store, grant)) begin
      res    = RES_FAULT;
      paddr  = '0;
      rights = '0;
    end else begin
      res    = RES_HIT;
      paddr  = {frame_word[ADDR_W-1 -: VPN_W], vaddr[OFS_W-1:0]};
      rights = grant;
    end
    code = res;
  end
endmodule

// File: rtl/tlb_exc_latch.sv
module tlb_exc_latch
  import tlb_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              fetch,
  input  logic [1:0]        code,
  input  logic [ADDR_W-1:0] vaddr,
  output logic              exc_valid,
  output logic [2:0]        exc_cause,
  output logic [ADDR_W-1:0] exc_addr
);
  logic raise;
  assign raise = req_valid && (code != RES_HIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_valid <= 1'b0;
      exc_cause <= CAUSE_NONE;
      exc_addr  <= '0;
    end else begin
      exc_valid <= raise;
      if (raise) begin
        exc_cause <= cause_of(fetch, res_e'(code));
        exc_addr  <= vaddr;
      end
    end
  end
endmodule

// File: rtl/tlb_xlate_unit.sv
module tlb_xlate_unit #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 13,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xlate_en,
  input  logic              priv_sup,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [1:0]        req_kind,
  input  logic              wr_en,
  input  logic              wr_side,
  input  logic              wr_sel,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [1:0]        rsp_code,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [2:0]        rsp_rights,
  output logic              exc_valid,
  output logic [2:0]        exc_cause,
  output logic [ADDR_W-1:0] exc_addr
);
  localparam int unsigned SIDES = 2;  // 0 data, 1 instruction

  logic              is_fetch;
  logic              is_store;
  logic [IDX_W-1:0]  slot_idx;
  logic [ADDR_W-1:0] side_tag   [SIDES];
  logic [ADDR_W-1:0] side_frame [SIDES];
  logic [ADDR_W-1:0] sel_tag;
  logic [ADDR_W-1:0] sel_frame;
  logic              lk_tag_hit;
  logic              lk_ent_valid;

  assign is_fetch = req_kind[1];
  assign is_store = !req_kind[1] && req_kind[0];
  assign slot_idx = req_vaddr[OFS_W +: IDX_W];

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    tlb_slot_store #(.WORD_W(ADDR_W), .IDX_W(IDX_W)) u_store (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en         (wr_en && (wr_side == s[0])),
      .wr_sel        (wr_sel),
      .wr_idx        (wr_idx),
      .wr_data       (wr_data),
      .rd_idx        (slot_idx),
      .rd_tag_word   (side_tag[s]),
      .rd_frame_word (side_frame[s])
    );
  end

  assign sel_tag   = side_tag[is_fetch];
  assign sel_frame = side_frame[is_fetch];

  tlb_lookup #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_lookup (
    .xlate_en   (xlate_en),
    .fetch      (is_fetch),
    .store      (is_store),
    .sup        (priv_sup),
    .vaddr      (req_vaddr),
    .tag_word   (sel_tag),
    .frame_word (sel_frame),
    .code       (rsp_code),
    .paddr      (rsp_paddr),
    .rights     (rsp_rights),
    .tag_hit    (lk_tag_hit),
    .ent_valid  (lk_ent_valid)
  );

  tlb_exc_latch #(.ADDR_W(ADDR_W)) u_exc (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .fetch     (is_fetch),
    .code      (rsp_code),
    .vaddr     (req_vaddr),
    .exc_valid (exc_valid),
    .exc_cause (exc_cause),
    .exc_addr  (exc_addr)
  );
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xlate_en,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic [1:0]        rsp_code,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic [2:0]        rsp_rights,
  input logic              exc_valid,
  input logic [2:0]        exc_cause,
  input logic [ADDR_W-1:0] exc_addr,
  input logic              lk_tag_hit,
  input logic              lk_ent_valid
);
  // R1
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xlate_en |-> (rsp_code == 2'd0 && rsp_paddr == req_vaddr && rsp_rights == 3'b111));

  // R2
  tag_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xlate_en && !lk_tag_hit) |-> rsp_code == 2'd1);

  // R3
  invalid_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xlate_en && lk_tag_hit && !lk_ent_valid) |-> rsp_code == 2'd1);

  // R6
  offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_code == 2'd0) |-> rsp_paddr[OFS_W-1:0] == req_vaddr[OFS_W-1:0]);

  // R7
  exc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_code != 2'd0) |=> (exc_valid && exc_cause != 3'd0));

  // R8
  exc_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_code != 2'd0) |=> exc_addr == $past(req_vaddr));

  // R8
  exc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_code != 2'd0) |=> ($stable(exc_addr) && !exc_valid));
endmodule

bind tlb_xlate_unit tlb_xlate_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .xlate_en     (xlate_en),
  .req_valid    (req_valid),
  .req_vaddr    (req_vaddr),
  .rsp_code     (rsp_code),
  .rsp_paddr    (rsp_paddr),
  .rsp_rights   (rsp_rights),
  .exc_valid    (exc_valid),
  .exc_cause    (exc_cause),
  .exc_addr     (exc_addr),
  .lk_tag_hit   (lk_tag_hit),
  .lk_ent_valid (lk_ent_valid)
);

// File: tb/test_tlb_xlate_unit.sv
module test_tlb_xlate_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xlate_en = 1'b0;
  logic        priv_sup = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        wr_en = 1'b0;
  logic        wr_side = 1'b0;
  logic        wr_sel = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_rights;
  logic        exc_valid;
  logic [2:0]  exc_cause;
  logic [31:0] exc_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_xlate_unit i_tlb_xlate_unit (
    .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .priv_sup(priv_sup),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind),
    .wr_en(wr_en), .wr_side(wr_side), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .rsp_code(rsp_code), .rsp_paddr(rsp_paddr),
    .rsp_rights(rsp_rights), .exc_valid(exc_valid), .exc_cause(exc_cause),
    .exc_addr(exc_addr)
  );

  typedef struct {
    string       tag;
    logic [1:0]  code;
    logic [31:0] paddr;
    logic [2:0]  rights;
    logic        exc;
    logic [2:0]  cause;
    logic [31:0] eaddr;
  } exp_t;

  exp_t        sb[$];
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 0;
  logic [31:0] sh_tag   [2][64];
  logic [31:0] sh_frame [2][64];
  logic [31:0] last_eaddr = '0;
  logic [2:0]  last_cause = '0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected result worked out from the requirement text
  function automatic exp_t predict(input string tag, input logic [31:0] va,
                                   input logic [1:0] kind, input logic sup,
                                   input logic en);
    exp_t        e;
    int          side;
    int          idx;
    logic [31:0] tw;
    logic [31:0] fw;
    logic        rr, ww, xx, ok;
    e.tag = tag; e.code = 2'd0; e.paddr = va; e.rights = 3'b111; e.exc = 1'b0;
    if (en) begin
      side = kind[1] ? 1 : 0;
      idx  = int'(va[18:13]);
      tw   = sh_tag[side][idx];
      fw   = sh_frame[side][idx];
      rr = 1'b0; ww = 1'b0; xx = 1'b0;
      if (side == 1) xx = sup ? fw[7] : fw[6];
      else begin
        rr = sup ? fw[8] : fw[6];
        ww = sup ? fw[9] : fw[7];
      end
      ok = (side == 1) ? xx : (kind[0] ? ww : rr);
      if (tw[31:13] != va[31:13] || tw[0] == 1'b0) begin
        e.code = 2'd1; e.paddr = '0; e.rights = '0; e.exc = 1'b1;
        e.cause = (side == 1) ? 3'd1 : 3'd2;
      end else if (!ok) begin
        e.code = 2'd2; e.paddr = '0; e.rights = '0; e.exc = 1'b1;
        e.cause = (side == 1) ? 3'd3 : 3'd4;
      end else begin
        e.paddr  = {fw[31:13], va[12:0]};
        e.rights = {xx, ww, rr};
      end
    end
    if (e.exc) begin
      last_eaddr = va;
      last_cause = e.cause;
    end
    e.eaddr = last_eaddr;
    e.cause = last_cause;
    return e;
  endfunction

  task automatic wr(input int side, input int sel, input int idx, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b0;
    wr_en = 1'b1; wr_side = side[0]; wr_sel = sel[0]; wr_idx = idx[5:0]; wr_data = d;
    if (sel == 0) sh_tag[side][idx] = d;
    else          sh_frame[side][idx] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic req(input string tag, input logic [31:0] va, input logic [1:0] kind,
                     input logic sup, input logic en);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = kind; priv_sup = sup; xlate_en = en;
    sb.push_back(predict(tag, va, kind, sup, en));
  endtask

  // Monitor: combinational response and registered exception seen at one point
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb.size() > 0) begin
        e = sb.pop_front();
        check(rsp_code == e.code, {e.tag, " code"}, 32'(rsp_code), 32'(e.code));
        check(rsp_paddr == e.paddr, {e.tag, " paddr"}, rsp_paddr, e.paddr);
        check(rsp_rights == e.rights, {e.tag, " rights"}, 32'(rsp_rights), 32'(e.rights));
        check(exc_valid == e.exc, {e.tag, " R7 exc_valid"}, 32'(exc_valid), 32'(e.exc));
        check(exc_cause == e.cause, {e.tag, " R7 exc_cause"}, 32'(exc_cause), 32'(e.cause));
        check(exc_addr == e.eaddr, {e.tag, " R8 exc_addr"}, exc_addr, e.eaddr);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  localparam logic [31:0] VA_A = {19'h12345, 13'h0ABC};

  initial begin
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 64; i++) begin
        sh_tag[s][i] = '0;
        sh_frame[s][i] = '0;
      end
    repeat (3) @(negedge clk);
    // R10 reset state
    check(exc_valid == 1'b0, "R10 reset exc_valid", 32'(exc_valid), 0);
    check(exc_cause == 3'd0, "R10 reset exc_cause", 32'(exc_cause), 0);
    check(exc_addr == 32'd0, "R10 reset exc_addr", exc_addr, 0);
    rst_n = 1'b1;

    req("R10 empty after reset load", VA_A, 2'd0, 1'b0, 1'b1);
    req("R10 empty after reset fetch", VA_A, 2'd2, 1'b1, 1'b1);
    req("R1 pass-through load", 32'hDEAD_BEEF, 2'd0, 1'b0, 1'b0);
    req("R1 pass-through fetch", 32'h0000_1FFF, 2'd2, 1'b1, 1'b0);
    req("R1 pass-through store", VA_A, 2'd1, 1'b0, 1'b0);

    // Data slot 5: user read, supervisor read+write
    wr(0, 0, 5, {19'h12345, 12'h0, 1'b1});
    wr(0, 1, 5, {19'h7A001, 13'h0} | (32'b1101 << 6));
    req("R6 user load hit", VA_A, 2'd0, 1'b0, 1'b1);
    req("R5 user store fault", VA_A, 2'd1, 1'b0, 1'b1);
    req("R5 sup store hit", VA_A + 32'h4, 2'd1, 1'b1, 1'b1);
    req("R5 sup load hit", VA_A + 32'h8, 2'd0, 1'b1, 1'b1);
    req("R2 tag mismatch miss", {19'h22345, 13'h0001}, 2'd0, 1'b1, 1'b1);

    // Data slot 9: tag right, valid flag clear
    wr(0, 0, 9, {19'h00049, 13'h0});
    wr(0, 1, 9, {19'h00111, 13'h0} | (32'b1111 << 6));
    req("R3 invalid slot miss", {19'h00049, 13'h0010}, 2'd1, 1'b1, 1'b1);

    // Instruction slot 5: supervisor execute only
    wr(1, 0, 5, {19'h00005, 12'h0, 1'b1});
    wr(1, 1, 5, {19'h03003, 13'h0} | (32'b10 << 6));
    req("R4 sup fetch hit", {19'h00005, 13'h0123}, 2'd2, 1'b1, 1'b1);
    req("R8 hold after hit", {19'h00005, 13'h0124}, 2'd3, 1'b1, 1'b1);
    req("R4 user fetch fault", {19'h00005, 13'h0200}, 2'd2, 1'b0, 1'b1);
    req("R9 fetch ignores data slot", VA_A, 2'd2, 1'b1, 1'b1);
    req("R9 load ignores instr slot", {19'h00005, 13'h0004}, 2'd0, 1'b1, 1'b1);
    req("R9 data slot intact", VA_A, 2'd0, 1'b0, 1'b1);

    // Make the valid flag of slot 9 set, and allow user write on slot 5
    wr(0, 0, 9, {19'h00049, 12'h0, 1'b1});
    req("R10 write visible next cycle", {19'h00049, 13'h0010}, 2'd1, 1'b1, 1'b1);
    wr(0, 1, 5, {19'h7A002, 13'h0} | (32'b0011 << 6));
    req("R5 user store now hit", VA_A, 2'd1, 1'b0, 1'b1);
    req("R5 sup load now fault", VA_A, 2'd0, 1'b1, 1'b1);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(sb.size() == 0, "scoreboard drained", 32'(sb.size()), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule